// File: doc/BRIEF.md
# I2C Control and Status Register Unit

This unit is the CPU-facing register front end of an I2C serial bus controller. One address on a simple register bus carries two different registers: a write there lands in a control register that cannot be read back, and a read there returns an engine status byte. Because the control side is write-only, software must always write complete control bytes and never rely on read-modify-write sequences.

Control writes are decoded into commands for the bus engine. These cover the operating mode, the master or slave role, the transmit or receive direction, single-cycle start and stop requests, and a release of the pending interrupt. A guarded two-write software reset is also decoded. Its single-cycle reset pulse also goes to the neighbouring address and control registers, which are not part of this unit. The status byte is captured from the engine every cycle. The interrupt-pending flag is kept locally, and it drives the interrupt line to the CPU.

Top module: `i2c_csr_unit`

## Requirements
- R1: After reset, the status byte reads 8'h10, cmd_master, cmd_tx, serial_en, irq, start_req, stop_req and sw_rst are 0, and cmd_mode is 2'b00.
- R2: A read at CSR_ADDR returns in the same cycle the status byte, bit 7 to bit 0: role, direction, busy, interrupt released, arbitration lost, address hit, general call, last bit. Every bit except bit 4 is the value the engine drove one cycle earlier. A read at any other address returns 8'h00.
- R3: A write at CSR_ADDR loads cmd_master from bit 7, cmd_tx from bit 6 and cmd_mode from bits 3:2, with the new values visible after the write's clock edge. Writes at any other address change none of the outputs.
- R4: serial_en is 1 only when cmd_mode is 2'b10. The values 2'b00 (port mode), 2'b01 and 2'b11 all give 0.
- R5: A write with bits 7, 6, 5 and 4 all set raises start_req for exactly one cycle after the write edge. The pulse is suppressed if the status busy bit (bit 5) was set when the write occurred.
- R6: A write with bits 7, 6 and 4 set and bit 5 clear raises stop_req for exactly one cycle, whether or not the bus is busy.
- R7: A write in which bit 7, bit 6 or bit 4 is clear produces neither start_req nor stop_req.
- R8: Writing bit 4 as 1 sets status bit 4 (released), and writing it as 0 leaves that bit unchanged. An eng_int_req pulse clears status bit 4, and it takes priority over a release written in the same cycle.
- R9: irq is 1 exactly when status bit 4 is 0 and cmd_mode is 2'b10.
- R10: A write with bits 1:0 equal to 2'b10, followed directly by the next write at CSR_ADDR with bits 1:0 equal to 2'b01, raises sw_rst for one cycle. That second write also returns the status byte to 8'h10 and clears cmd_master and cmd_tx, while cmd_mode takes the written bits 3:2.
- R11: The reset sequence is cancelled when the write that follows a 2'b10 write at CSR_ADDR carries bits 1:0 of 2'b00 or 2'b11. A repeated 2'b10 write re-arms the sequence. Reads and writes at other addresses leave the armed state untouched.
- R12: The write that completes a software reset issues neither start_req nor stop_req, even when bits 7, 6, 5 and 4 are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | ADDR_W | Register bus address |
| cpu_wr | input | 1 | Write strobe |
| cpu_rd | input | 1 | Read strobe |
| cpu_wdata | input | 8 | Write data (control byte) |
| cpu_rdata | output | 8 | Read data (status byte or zero) |
| eng_master | input | 1 | Engine reports master role |
| eng_tx | input | 1 | Engine reports transmitter direction |
| eng_busy | input | 1 | Bus busy |
| eng_arb_lost | input | 1 | Arbitration lost |
| eng_addr_hit | input | 1 | Own address or general call matched |
| eng_gcall | input | 1 | General call detected |
| eng_last_bit | input | 1 | Last received bit |
| eng_int_req | input | 1 | Engine raises an interrupt request (pulse) |
| cmd_master | output | 1 | Commanded role, 1 = master |
| cmd_tx | output | 1 | Commanded direction, 1 = transmit |
| cmd_mode | output | 2 | Commanded operating mode |
| serial_en | output | 1 | Serial outputs enabled (I2C mode) |
| start_req | output | 1 | Start condition request pulse |
| stop_req | output | 1 | Stop condition request pulse |
| sw_rst | output | 1 | Software reset pulse to the engine and neighbour registers |
| irq | output | 1 | Interrupt to the CPU |

## Verification
The bench builds the unit with ADDR_W = 5 and CSR_ADDR = 5'h13, so the whole address space is only 32 locations. That makes it affordable to write a full control byte at every foreign address and confirm that each one is ignored. It also lets the bench place foreign-address writes and reads between the two steps of the reset sequence. With that narrow address space the bench covers the busy-gated start, the stop accepted while busy, the write-only cancel, the engine-over-cancel priority and each way the reset sequence can be cancelled.

// File: rtl/i2c_csr_pkg.sv
package i2c_csr_pkg;

    typedef enum logic [1:0] {
        MODE_PORT = 2'b00,
        MODE_RSV1 = 2'b01,
        MODE_I2C  = 2'b10,
        MODE_RSV3 = 2'b11
    } bus_mode_e;

    // Control byte as written by the CPU, bit 7 first.
    typedef struct packed {
        logic      role;
        logic      dir;
        logic      start_not_stop;
        logic      cancel;
        bus_mode_e mode;
        logic [1:0] rst_field;
    } ctrl_wr_t;

    // Status byte as read by the CPU, bit 7 first.
    typedef struct packed {
        logic role;
        logic dir;
        logic busy;
        logic released;
        logic arb_lost;
        logic addr_hit;
        logic gcall;
        logic last_bit;
    } stat_t;

    localparam int    BYTE_W    = $bits(stat_t);
    localparam stat_t STAT_INIT = stat_t'(8'h10);

    localparam logic [1:0] RST_STEP_ARM  = 2'b10;
    localparam logic [1:0] RST_STEP_FIRE = 2'b01;

    // Start or stop is only honoured when role, direction and cancel are all set.
    function automatic logic cond_cmd_ok(input ctrl_wr_t w);
        return w.role & w.dir & w.cancel;
    endfunction

endpackage

// File: rtl/i2c_swrst_seq.sv
module i2c_swrst_seq
    import i2c_csr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_hit,
    input  logic [1:0] field,
    output logic       fire,
    output logic       pulse
);

    logic armed_q;

    always_comb fire = wr_hit && armed_q && (field == RST_STEP_FIRE);

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            pulse   <= 1'b0;
        end else begin
            pulse <= fire;
            if (wr_hit)
                armed_q <= (field == RST_STEP_ARM);
        end
    end

endmodule

// File: rtl/i2c_ctrl_decode.sv
module i2c_ctrl_decode
    import i2c_csr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_hit,
    input  ctrl_wr_t  wr,
    input  logic      fire,
    input  logic      busy,
    output logic      master,
    output logic      tx,
    output bus_mode_e mode,
    output logic      start_p,
    output logic      stop_p
);

    logic go;

    always_comb go = wr_hit && !fire && cond_cmd_ok(wr);

    always_ff @(posedge clk) begin
        if (rst) begin
            master  <= 1'b0;
            tx      <= 1'b0;
            mode    <= MODE_PORT;
            start_p <= 1'b0;
            stop_p  <= 1'b0;
        end else begin
            start_p <= go && wr.start_not_stop && !busy;
            stop_p  <= go && !wr.start_not_stop;
            if (fire) begin
                master <= 1'b0;
                tx     <= 1'b0;
                mode   <= wr.mode;
            end else if (wr_hit) begin
                master <= wr.role;
                tx     <= wr.dir;
                mode   <= wr.mode;
            end
        end
    end

endmodule

// File: rtl/i2c_status_reg.sv
module i2c_status_reg
    import i2c_csr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  fire,
    input  logic  cancel_wr,
    input  logic  int_req,
    input  logic  eng_master,
    input  logic  eng_tx,
    input  logic  eng_busy,
    input  logic  eng_arb_lost,
    input  logic  eng_addr_hit,
    input  logic  eng_gcall,
    input  logic  eng_last_bit,
    output stat_t stat
);

    always_ff @(posedge clk) begin
        if (rst || fire) begin
            stat <= STAT_INIT;
        end else begin
            stat.role     <= eng_master;
            stat.dir      <= eng_tx;
            stat.busy     <= eng_busy;
            stat.arb_lost <= eng_arb_lost;
            stat.addr_hit <= eng_addr_hit;
            stat.gcall    <= eng_gcall;
            stat.last_bit <= eng_last_bit;
            if (int_req)
                stat.released <= 1'b0;
            else if (cancel_wr)
                stat.released <= 1'b1;
        end
    end

endmodule

// File: rtl/i2c_csr_unit.sv
module i2c_csr_unit
    import i2c_csr_pkg::*;
#(
    parameter int              ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] CSR_ADDR = 8'h3A
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [7:0]        cpu_wdata,
    output logic [7:0]        cpu_rdata,
    input  logic              eng_master,
    input  logic              eng_tx,
    input  logic              eng_busy,
    input  logic              eng_arb_lost,
    input  logic              eng_addr_hit,
    input  logic              eng_gcall,
    input  logic              eng_last_bit,
    input  logic              eng_int_req,
    output logic              cmd_master,
    output logic              cmd_tx,
    output logic [1:0]        cmd_mode,
    output logic              serial_en,
    output logic              start_req,
    output logic              stop_req,
    output logic              sw_rst,
    output logic              irq
);

    logic      wr_hit;
    logic      rd_hit;
    logic      fire;
    logic      cancel_wr;
    ctrl_wr_t  wr_fields;
    stat_t     stat_q;
    bus_mode_e mode_q;

    always_comb begin
        wr_hit    = cpu_wr && (cpu_addr == CSR_ADDR);
        rd_hit    = cpu_rd && (cpu_addr == CSR_ADDR);
        wr_fields = ctrl_wr_t'(cpu_wdata);
        cancel_wr = wr_hit && wr_fields.cancel;
    end

    i2c_swrst_seq u_seq (
        .clk   (clk),
        .rst   (rst),
        .wr_hit(wr_hit),
        .field (wr_fields.rst_field),
        .fire  (fire),
        .pulse (sw_rst)
    );

    i2c_ctrl_decode u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .wr_hit (wr_hit),
        .wr     (wr_fields),
        .fire   (fire),
        .busy   (stat_q.busy),
        .master (cmd_master),
        .tx     (cmd_tx),
        .mode   (mode_q),
        .start_p(start_req),
        .stop_p (stop_req)
    );

    i2c_status_reg u_stat (
        .clk         (clk),
        .rst         (rst),
        .fire        (fire),
        .cancel_wr   (cancel_wr),
        .int_req     (eng_int_req),
        .eng_master  (eng_master),
        .eng_tx      (eng_tx),
        .eng_busy    (eng_busy),
        .eng_arb_lost(eng_arb_lost),
        .eng_addr_hit(eng_addr_hit),
        .eng_gcall   (eng_gcall),
        .eng_last_bit(eng_last_bit),
        .stat        (stat_q)
    );

    always_comb begin
        cmd_mode  = mode_q;
        serial_en = (mode_q == MODE_I2C);
        irq       = !stat_q.released && serial_en;
        cpu_rdata = rd_hit ? BYTE_W'(stat_q) : '0;
    end

endmodule

// File: rtl/i2c_csr_chk.sv
module i2c_csr_chk #(
    parameter int              ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] CSR_ADDR = 8'h3A
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_wr,
    input logic [7:0]        cpu_wdata,
    input logic              start_req,
    input logic              stop_req,
    input logic              sw_rst,
    input logic              cmd_master,
    input logic              serial_en,
    input logic              irq,
    input logic [7:0]        stat
);

    logic wr_hit;
    always_comb wr_hit = cpu_wr && (cpu_addr == CSR_ADDR);

    a_r3_master_only_on_write: assert property (@(posedge clk) disable iff (rst)
        !$stable(cmd_master) |-> $past(wr_hit));

    a_r4_mode_enables_serial: assert property (@(posedge clk) disable iff (rst)
        wr_hit |=> (serial_en == ($past(cpu_wdata[3:2]) == 2'b10)));

    a_r5_start_cause: assert property (@(posedge clk) disable iff (rst)
        start_req |-> $past(wr_hit && (cpu_wdata[7:4] == 4'hF) && !stat[5]));

    a_r6_stop_cause: assert property (@(posedge clk) disable iff (rst)
        stop_req |-> $past(wr_hit && cpu_wdata[7] && cpu_wdata[6] && !cpu_wdata[5] && cpu_wdata[4]));

    a_r7_start_stop_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(start_req && stop_req));

    a_r9_irq_needs_i2c: assert property (@(posedge clk) disable iff (rst)
        irq |-> serial_en);

    a_r10_reset_cause: assert property (@(posedge clk) disable iff (rst)
        sw_rst |-> $past(wr_hit && (cpu_wdata[1:0] == 2'b01)));

    a_r10_status_init: assert property (@(posedge clk) disable iff (rst)
        sw_rst |-> (stat == 8'h10));

    a_r12_no_cmd_on_reset: assert property (@(posedge clk) disable iff (rst)
        sw_rst |-> (!start_req && !stop_req && !cmd_master));

endmodule

bind i2c_csr_unit i2c_csr_chk #(
    .ADDR_W  (ADDR_W),
    .CSR_ADDR(CSR_ADDR)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cpu_addr  (cpu_addr),
    .cpu_wr    (cpu_wr),
    .cpu_wdata (cpu_wdata),
    .start_req (start_req),
    .stop_req  (stop_req),
    .sw_rst    (sw_rst),
    .cmd_master(cmd_master),
    .serial_en (serial_en),
    .irq       (irq),
    .stat      (stat_q)
);

// File: tb/tb_i2c_csr_unit.sv
module tb_i2c_csr_unit;

    localparam int             AW = 5;
    localparam logic [AW-1:0]  CA = 5'h13;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] cpu_addr = '0;
    logic          cpu_wr = 1'b0;
    logic          cpu_rd = 1'b0;
    logic [7:0]    cpu_wdata = '0;
    logic [7:0]    cpu_rdata;
    logic eng_master = 0, eng_tx = 0, eng_busy = 0, eng_arb_lost = 0;
    logic eng_addr_hit = 0, eng_gcall = 0, eng_last_bit = 0, eng_int_req = 0;
    logic       cmd_master, cmd_tx, serial_en, start_req, stop_req, sw_rst, irq;
    logic [1:0] cmd_mode;

    int   n_chk  = 0;
    int   n_fail = 0;
    logic [7:0] post_stat;

    always #10 clk = ~clk;

    i2c_csr_unit #(.ADDR_W(AW), .CSR_ADDR(CA)) dut (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .eng_master(eng_master), .eng_tx(eng_tx), .eng_busy(eng_busy),
        .eng_arb_lost(eng_arb_lost), .eng_addr_hit(eng_addr_hit), .eng_gcall(eng_gcall),
        .eng_last_bit(eng_last_bit), .eng_int_req(eng_int_req),
        .cmd_master(cmd_master), .cmd_tx(cmd_tx), .cmd_mode(cmd_mode),
        .serial_en(serial_en), .start_req(start_req), .stop_req(stop_req),
        .sw_rst(sw_rst), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Write, then peek at the status in the cycle right after the write edge.
    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0; cpu_addr = CA; cpu_rd = 1'b1;
        #1 post_stat = cpu_rdata;
        cpu_rd = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_rd = 1'b1;
        #1 d = cpu_rdata;
        cpu_rd = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(CA, d);
        chk("R1 status", d, 8'h10);
        chk("R1 outputs", {cmd_master, cmd_tx, serial_en, irq, start_req, stop_req, sw_rst, 1'b0}, 8'h00);
        chk("R1 mode", {6'd0, cmd_mode}, 8'h00);
    endtask

    task automatic t_read_map();
        logic [7:0] d;
        eng_master = 1; eng_tx = 0; eng_busy = 1; eng_arb_lost = 0;
        eng_addr_hit = 1; eng_gcall = 0; eng_last_bit = 1;
        idle();
        rd(CA, d);
        chk("R2 pattern a", d, 8'hB5);
        rd(CA + 5'd1, d);
        chk("R2 other addr", d, 8'h00);
        eng_master = 0; eng_tx = 1; eng_busy = 0; eng_arb_lost = 1;
        eng_addr_hit = 0; eng_gcall = 1; eng_last_bit = 0;
        idle();
        rd(CA, d);
        chk("R2 pattern b", d, 8'h5A);
        eng_tx = 0; eng_arb_lost = 0; eng_gcall = 0;
        idle();
    endtask

    task automatic t_write_decode();
        for (int a = 0; a < 32; a++) begin
            if (a[AW-1:0] != CA) begin
                wr(a[AW-1:0], 8'hC8);
                chk("R3 foreign write ignored", {cmd_master, cmd_tx, serial_en, 3'd0, cmd_mode}, 8'h00);
            end
        end
        wr(CA, 8'hC8);
        chk("R3 load", {cmd_master, cmd_tx, 4'd0, cmd_mode}, 8'hC2);
        wr(CA, 8'h40);
        chk("R3 reload", {cmd_master, cmd_tx, 4'd0, cmd_mode}, 8'h40);
    endtask

    task automatic t_mode();
        wr(CA, 8'h00); chk("R4 mode 00", {7'd0, serial_en}, 8'h00);
        wr(CA, 8'h04); chk("R4 mode 01", {7'd0, serial_en}, 8'h00);
        wr(CA, 8'h08); chk("R4 mode 10", {7'd0, serial_en}, 8'h01);
        wr(CA, 8'h0C); chk("R4 mode 11", {7'd0, serial_en}, 8'h00);
    endtask

    task automatic t_start_stop();
        eng_busy = 0; idle();
        wr(CA, 8'hF8);
        chk("R5 start pulse", {6'd0, start_req, stop_req}, 8'h02);
        idle();
        chk("R5 start single cycle", {7'd0, start_req}, 8'h00);
        eng_busy = 1; idle();
        wr(CA, 8'hF8);
        chk("R5 start blocked by busy", {6'd0, start_req, stop_req}, 8'h00);
        wr(CA, 8'hD8);
        chk("R6 stop while busy", {6'd0, start_req, stop_req}, 8'h01);
        idle();
        chk("R6 stop single cycle", {7'd0, stop_req}, 8'h00);
        eng_busy = 0; idle();
        wr(CA, 8'h78); chk("R7 role clear", {6'd0, start_req, stop_req}, 8'h00);
        wr(CA, 8'hB8); chk("R7 dir clear", {6'd0, start_req, stop_req}, 8'h00);
        wr(CA, 8'hE8); chk("R7 cancel clear", {6'd0, start_req, stop_req}, 8'h00);
        wr(CA, 8'h58); chk("R7 stop role clear", {6'd0, start_req, stop_req}, 8'h00);
    endtask

    task automatic t_pending();
        wr(CA, 8'h08);
        @(negedge clk); eng_int_req = 1;
        @(negedge clk); eng_int_req = 0;
        chk("R9 irq in i2c mode", {7'd0, irq}, 8'h01);
        wr(CA, 8'h08);
        chk("R8 cancel 0 no effect", post_stat, 8'h00);
        chk("R9 irq held", {7'd0, irq}, 8'h01);
        wr(CA, 8'h00);
        chk("R9 irq off in port mode", {7'd0, irq}, 8'h00);
        wr(CA, 8'h18);
        chk("R8 cancel releases", post_stat, 8'h10);
        chk("R9 irq clear after release", {7'd0, irq}, 8'h00);
        eng_int_req = 1;
        wr(CA, 8'h18);
        eng_int_req = 0;
        chk("R8 engine wins over cancel", post_stat, 8'h00);
        wr(CA, 8'h18);
        chk("R8 release again", post_stat, 8'h10);
    endtask

    task automatic t_swrst();
        logic [7:0] d;
        eng_busy = 1; idle();
        wr(CA, 8'hCA);
        chk("R10 armed, no pulse", {cmd_master, 6'd0, sw_rst}, 8'h80);
        wr(CA, 8'h89);
        chk("R10 pulse", {7'd0, sw_rst}, 8'h01);
        chk("R10 fields cleared", {cmd_master, cmd_tx, 4'd0, cmd_mode}, 8'h02);
        chk("R10 status init", post_stat, 8'h10);
        idle();
        chk("R10 single pulse", {7'd0, sw_rst}, 8'h00);
        rd(CA, d);
        chk("R10 status recaptures", d, 8'h30);
        eng_busy = 0; idle();
        wr(CA, 8'h0A);
        wr(CA, 8'hF9);
        chk("R12 reset write no cmd", {5'd0, sw_rst, start_req, stop_req}, 8'h04);
        chk("R12 role cleared", {7'd0, cmd_master}, 8'h00);
    endtask

    task automatic t_swrst_cancel();
        logic [7:0] d;
        wr(CA, 8'h0A); wr(CA, 8'h08); wr(CA, 8'h09);
        chk("R11 cancel by 00", {7'd0, sw_rst}, 8'h00);
        wr(CA, 8'h0A); wr(CA, 8'h0B); wr(CA, 8'h09);
        chk("R11 cancel by 11", {7'd0, sw_rst}, 8'h00);
        wr(CA, 8'h0A); wr(CA, 8'h0A); wr(CA, 8'h09);
        chk("R11 rearm by 10", {7'd0, sw_rst}, 8'h01);
        wr(CA, 8'h0A);
        rd(CA, d);
        wr(CA + 5'd2, 8'h08);
        wr(CA, 8'h09);
        chk("R11 foreign traffic keeps arm", {7'd0, sw_rst}, 8'h01);
        wr(CA, 8'h09);
        chk("R11 no fire without arm", {7'd0, sw_rst}, 8'h00);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_read_map();
        t_write_decode();
        t_mode();
        t_start_stop();
        t_pending();
        t_swrst();
        t_swrst_cancel();
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule